// File: doc/BRIEF.md
# Power-managed single-port RAM

A behavioural, synthesizable model of a single-port word memory with three power-control inputs. Each clock edge either reads one word, writes one word, or does nothing. Writes can be restricted to selected 4-bit nibbles of the word. The read word appears on the output right after the edge that captured the address. There is no further output register.

Three power controls override normal access. Standby freezes the output and keeps the contents. Sleep forces the output to zero and keeps the contents. Powering the core off forces the output to zero and loses every stored word. After power-off, a word reads as zero until it is written again.

The full-size configuration sets `ADDR_W` to 14, giving 16,384 words of 16 bits. The default elaboration uses a smaller depth.

Top module: `pm_sp_ram`

## Requirements
- R1: The array holds 2**ADDR_W words of DATA_W bits. A word written at an address is returned by a later read of that address, and other addresses are not affected.
- R2: With `cs`=1, `wr_en`=0 and all power controls in the normal state (`standby`=0, `sleep`=0, `pwr_en`=1), the word at `addr` is presented on `rdata` directly after that clock edge.
- R3: Bit i of `wmask` enables the write of data bits 4i+3:4i. A 1 writes that nibble from `wdata`. A 0 leaves the stored nibble unchanged.
- R4: `rdata` keeps its last value during write cycles and while `cs`=0. A write attempted with `cs`=0 does not change the memory.
- R5: While `standby`=1, no read or write takes place, `rdata` holds its value and the contents are kept.
- R6: While `sleep`=1, `rdata` is all zeros from the moment sleep rises. After sleep falls, `rdata` stays zero until the next read. Contents are kept and no access takes place. `sleep` and `standby` must never be high together.
- R7: While `pwr_en`=0, `rdata` is all zeros and no access takes place. Every stored word is lost: after power returns, each word reads as zero until it is written again.
- R8: Precedence is power-off first, then sleep, then standby. A read or write request made while any of these is active has no effect.
- R9: A masked write to a word that holds no data (never written since power-up) leaves the unwritten nibbles reading as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; address and data are captured on its rising edge |
| addr | input | ADDR_W | Word address |
| wdata | input | DATA_W | Write data |
| wr_en | input | 1 | 1 = write cycle, 0 = read cycle |
| cs | input | 1 | Access enable; 0 = no access |
| wmask | input | DATA_W/4 | Per-nibble write enable, bit i covers bits 4i+3:4i |
| standby | input | 1 | Hold state: output frozen, contents kept |
| sleep | input | 1 | Deep sleep: output zero, contents kept |
| pwr_en | input | 1 | Core power, active high; 0 loses the contents |
| rdata | output | DATA_W | Read data |

## Verification
The bench targets several corner cases, each paired with the wrong behaviour it would expose:
- Masked writes with mixed nibble patterns: a design with a wrong nibble-to-mask mapping would corrupt neighbouring nibbles or drop the written one.
- Reads of never-written words after a power cycle: a design that kept the stored data would return stale values instead of zeros.
- Sleep asserted between edges: a design that only clears the output at the next edge would show the old word for part of a cycle.
- Read and write requests made under each power condition, including combined ones: a design that ignored the precedence order would perform an access or leave a non-zero output.

// File: rtl/pm_sp_ram.sv
module pm_sp_ram #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              wr_en,
  input  logic              cs,
  input  logic [DATA_W/4-1:0] wmask,
  input  logic              standby,
  input  logic              sleep,
  input  logic              pwr_en,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int NIB   = DATA_W / 4;

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DEPTH-1:0]  vld;
  logic [DATA_W-1:0] q;
  logic [DATA_W-1:0] bmask;

  wire active = pwr_en & ~sleep & ~standby;
  wire [DATA_W-1:0] cur    = vld[addr] ? mem[addr] : '0;
  wire [DATA_W-1:0] merged = (wdata & bmask) | (cur & ~bmask);

  for (genvar g = 0; g < NIB; g++) begin : g_nib
    assign bmask[4*g +: 4] = {4{wmask[g]}};
  end

  always_ff @(posedge clk)
    if (active && cs && wr_en) mem[addr] <= merged;

  always_ff @(posedge clk) begin
    if (!pwr_en) begin
      vld <= '0;
      q   <= '0;
    end else if (sleep) begin
      q <= '0;
    end else if (active && cs) begin
      if (wr_en) vld[addr] <= 1'b1;
      else       q <= cur;
    end
  end

  assign rdata = (pwr_en && !sleep) ? q : '0;
endmodule

module pm_sp_ram_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              cs,
  input logic              wr_en,
  input logic              standby,
  input logic              sleep,
  input logic              pwr_en,
  input logic [DATA_W-1:0] rdata
);
  p_hold_idle_r4: assert property (@(posedge clk) disable iff (!pwr_en)
    (!sleep && !standby && (!cs || wr_en)) |=> ($stable(rdata) || sleep));

  p_standby_hold_r5: assert property (@(posedge clk) disable iff (!pwr_en)
    (standby && !sleep) |=> ($stable(rdata) || sleep));

  p_sleep_zero_r6: assert property (@(posedge clk) disable iff (!pwr_en)
    sleep |=> (rdata == '0));

  p_excl_r6: assert property (@(posedge clk) disable iff (!pwr_en)
    !(standby && sleep));

  p_wake_zero_r7: assert property (@(posedge clk) disable iff (!pwr_en)
    $rose(pwr_en) |-> (rdata == '0));
endmodule

bind pm_sp_ram pm_sp_ram_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_pm_sp_ram.sv
module tb_pm_sp_ram;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 11;
  localparam int DW = 16;
  localparam int DEPTH = 1 << AW;

  logic clk = 0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic wr_en = 0, cs = 0, standby = 0, sleep = 0, pwr_en = 0;
  logic [DW/4-1:0] wmask = '1;
  logic [DW-1:0] rdata;

  int checks = 0, fails = 0;
  logic [DW-1:0] m [DEPTH];
  bit v [DEPTH];
  logic [DW-1:0] eq = '0;

  pm_sp_ram #(.ADDR_W(AW), .DATA_W(DW)) dut (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DW-1:0] merge(logic [DW-1:0] old, logic [DW-1:0] d, logic [DW/4-1:0] mk);
    logic [DW-1:0] r = old;
    for (int i = 0; i < DW/4; i++) if (mk[i]) r[4*i +: 4] = d[4*i +: 4];
    return r;
  endfunction

  function automatic logic [DW-1:0] expect_out();
    return (pwr_en && !sleep) ? eq : '0;
  endfunction

  task automatic check(string tag, logic [DW-1:0] exp);
    checks++;
    if (rdata !== exp) begin
      fails++;
      $display("FAIL %s: rdata=%h expected=%h", tag, rdata, exp);
    end
  endtask

  // called at a negedge; drives, clocks, updates model, checks at next negedge
  task automatic op(string tag, bit c, bit w, logic [AW-1:0] a, logic [DW-1:0] d,
                    logic [DW/4-1:0] mk, bit sb, bit sl, bit pw);
    cs = c; wr_en = w; addr = a; wdata = d; wmask = mk;
    standby = sb; sleep = sl; pwr_en = pw;
    @(posedge clk);
    if (!pw) begin
      for (int i = 0; i < DEPTH; i++) v[i] = 0;
      eq = '0;
    end else if (sl) eq = '0;
    else if (!sb && c) begin
      if (w) begin m[a] = merge(v[a] ? m[a] : '0, d, mk); v[a] = 1; end
      else eq = v[a] ? m[a] : '0;
    end
    @(negedge clk);
    check(tag, expect_out());
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: rdata=%h expected=done", rdata);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < DEPTH; i++) v[i] = 0;
    @(negedge clk);
    check("R7 reset", '0);
    op("R7 off", 0, 0, 0, 0, '1, 0, 0, 0);
    op("R7 off", 0, 0, 0, 0, '1, 0, 0, 0);
    // R1/R2
    op("R1 wr", 1, 1, 5, 16'hA5C3, '1, 0, 0, 1);
    op("R1 wr", 1, 1, 6, 16'h1234, '1, 0, 0, 1);
    op("R2 rd", 1, 0, 5, 0, '1, 0, 0, 1);
    check("R2 val", 16'hA5C3);
    op("R1 rd", 1, 0, 6, 0, '1, 0, 0, 1);
    // R3 mask
    op("R3 wr", 1, 1, 5, 16'hFFFF, 4'b0101, 0, 0, 1);
    op("R3 rd", 1, 0, 5, 0, '1, 0, 0, 1);
    check("R3 val", 16'hAFCF);
    // R4 hold on write / cs low, cs-low write ignored
    op("R4 whold", 1, 1, 7, 16'h7777, '1, 0, 0, 1);
    check("R4 whold", 16'hAFCF);
    op("R4 cs0", 0, 1, 6, 16'hDEAD, '1, 0, 0, 1);
    op("R4 rd", 1, 0, 6, 0, '1, 0, 0, 1);
    check("R4 val", 16'h1234);
    // R5 standby: read and write ignored
    op("R5 rd", 1, 0, 7, 0, '1, 1, 0, 1);
    check("R5 hold", 16'h1234);
    op("R5 wr", 1, 1, 6, 16'hBEEF, '1, 1, 0, 1);
    op("R5 rd", 1, 0, 6, 0, '1, 0, 0, 1);
    check("R5 kept", 16'h1234);
    // R6 sleep: immediate zero, stays zero after wake, contents kept
    sleep = 1; #1; check("R6 imm", '0);
    op("R6 wr", 1, 1, 6, 16'hBEEF, '1, 0, 1, 1);
    op("R6 idle", 0, 0, 0, 0, '1, 0, 0, 1);
    check("R6 wake", '0);
    op("R6 rd", 1, 0, 6, 0, '1, 0, 0, 1);
    check("R6 kept", 16'h1234);
    // R8 precedence: power-off with sleep and with standby + write
    op("R8 off", 1, 1, 6, 16'hCAFE, '1, 0, 1, 0);
    op("R8 off", 1, 1, 9, 16'hCAFE, '1, 1, 0, 0);
    op("R8 rd", 1, 0, 9, 0, '1, 0, 0, 1);
    check("R8 val", '0);
    // R7 contents lost
    op("R7 rd", 1, 0, 6, 0, '1, 0, 0, 1);
    check("R7 lost", '0);
    // R9 masked write to empty word
    op("R9 wr", 1, 1, 20, 16'h9876, 4'b1001, 0, 0, 1);
    op("R9 rd", 1, 0, 20, 0, '1, 0, 0, 1);
    check("R9 val", 16'h9006);
    // random
    for (int n = 0; n < 3000; n++) begin
      int r = $urandom_range(0, 99);
      bit sb = (r < 8);
      bit sl = (r >= 8 && r < 13);
      bit pw = !(r == 99);
      op("R2 rand", $urandom_range(0, 3) != 0, $urandom_range(0, 1),
         AW'($urandom_range(0, 31)), DW'($urandom), 4'($urandom), sb, sl, pw);
    end
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule